// File: doc/BRIEF.md
# Serial Configuration EEPROM Reader

This block drives a three-wire serial EEPROM through its read command. It controls chip select, the serial clock and the data line into the device, and it shifts in the device's data output. After reset it reads every word of the 64-word configuration image in turn. From word 0 it decides whether an image is present, and it keeps the words that hold a 48-bit station address. Once this auto-load ends, a host may fetch any single word by its 6-bit address. The block returns that word with a one-cycle acknowledge.

Every serial clock phase lasts `PHASE_CLKS` system clocks, so the EEPROM clock rate can be set to suit the device. A transfer has these steps. Chip select rises for one settle phase. Nine command and address bits go out, each as a low, high, low sequence. Sixteen data bits come back, each as a high phase then a low phase. Chip select then falls for one idle phase.

Top module: `cfg_rom_loader`

## Requirements
- R1: While reset is held, `rom_cs`, `rom_sck`, `load_done`, `image_ok` and `host_ack` are all 0.
- R2: `rom_sck` is high only while `rom_cs` is high. Chip select stays high from one phase before the first clock rise until after the last data bit.
- R3: Each transfer sends the opcode bits 1, 1, 0 and then the 6-bit word address, most significant bit first, on `rom_di`. The device captures each bit on a rising edge of `rom_sck`.
- R4: `rom_di` changes only while `rom_sck` is low. Every high phase of `rom_sck` lasts exactly `PHASE_CLKS` system clocks.
- R5: After the address, sixteen data bits are taken from `rom_do` most significant bit first. Each bit is sampled at the end of a `rom_sck` high phase.
- R6: After reset the block reads words 0 to 63 in ascending order, with exactly one transfer per word. `busy` is high and `load_done` is low until the last word arrives. After that `load_done` stays high until the next reset.
- R7: After the load, `image_ok` is 0 when word 0 is 16'h0000 or 16'hFFFF, and 1 for any other value.
- R8: When `image_ok` is 1, octet k of `station_addr` (bits 8k+7:8k, k = 0..5) is image byte 20+k. Image byte 2w is the low byte of word w and byte 2w+1 is its high byte, so the octets come from words 10, 11 and 12. When `image_ok` is 0, `station_addr` is zero.
- R9: With `busy` low, a `host_req` pulse starts a single-word read of `host_addr`. When it ends, `host_ack` pulses for one cycle and `host_data` holds the word.
- R10: A `host_req` that arrives while `busy` is high is ignored. It starts no transfer and produces no acknowledge, both during the auto-load and during a host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-word read request |
| host_addr | input | 6 | Word address for a host read |
| host_ack | output | 1 | One-cycle pulse when host_data is valid |
| host_data | output | 16 | Word returned by a host read |
| busy | output | 1 | A transfer or the auto-load is in progress |
| load_done | output | 1 | Auto-load finished |
| image_ok | output | 1 | The image is present (word 0 is neither all zeros nor all ones) |
| station_addr | output | 48 | Station address, octet k = image byte 20+k |
| rom_cs | output | 1 | EEPROM chip select |
| rom_sck | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Serial data to the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench models the EEPROM. It fills the image with seeded random words, and with fixed random words it runs the load again using a word 0 of 16'hFFFF, 16'h0000, 16'h0001 and 16'hFFFE. The two blank patterns must clear `image_ok` and `station_addr`. The two values next to them must not, which separates a correct all-ones/all-zeros test from a looser compare. Random single-word reads, plus reads of addresses 0 and 63, test the bit order of the address and of the data, because a reversed or shifted bit returns a different word. Requests during the load and requests one cycle after a host read is accepted test the busy gating.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

    // Serial engine phases; each lasts one timer period
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SEL,
        ENG_TX_LO1,
        ENG_TX_HI,
        ENG_TX_LO2,
        ENG_RX_HI,
        ENG_RX_LO,
        ENG_GAP
    } eng_state_e;

    // Top-level sequencing
    typedef enum logic [1:0] {
        CTL_LOAD_ISSUE,
        CTL_LOAD_WAIT,
        CTL_READY,
        CTL_HOST_WAIT
    } ctl_state_e;

    localparam int          OPCODE_W    = 3;
    localparam logic [2:0]  READ_OPCODE = 3'b110;

endpackage

// File: rtl/rom_phase_timer.sv
module rom_phase_timer #(
    parameter int PHASE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CLKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign phase_end = run && (cnt_q == LAST);

endmodule

// File: rtl/rom_bit_engine.sv
module rom_bit_engine
    import cfg_rom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              phase_end,
    input  logic              rom_do,
    output logic              active,
    output logic              rom_cs,
    output logic              rom_sck,
    output logic              rom_di,
    output logic              done,
    output logic [WORD_W-1:0] data
);
    localparam int CMD_W = OPCODE_W + ADDR_W;
    localparam int MAXB  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int BIT_W = $clog2(MAXB);

    typedef struct packed {
        eng_state_e        st;
        logic [CMD_W-1:0]  tx;
        logic [BIT_W-1:0]  bit_i;
        logic [WORD_W-1:0] rx;
        logic              done;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ENG_IDLE: begin
                if (start) begin
                    r_d.st    = ENG_SEL;
                    r_d.tx    = {READ_OPCODE, addr};
                    r_d.bit_i = BIT_W'(CMD_W - 1);
                end
            end
            ENG_SEL: begin
                if (phase_end) r_d.st = ENG_TX_LO1;
            end
            ENG_TX_LO1: begin
                if (phase_end) r_d.st = ENG_TX_HI;
            end
            ENG_TX_HI: begin
                if (phase_end) r_d.st = ENG_TX_LO2;
            end
            ENG_TX_LO2: begin
                if (phase_end) begin
                    if (r_q.bit_i == '0) begin
                        r_d.st    = ENG_RX_HI;
                        r_d.bit_i = BIT_W'(WORD_W - 1);
                    end else begin
                        r_d.st    = ENG_TX_LO1;
                        r_d.bit_i = r_q.bit_i - 1'b1;
                    end
                end
            end
            ENG_RX_HI: begin
                if (phase_end) begin
                    r_d.rx = {r_q.rx[WORD_W-2:0], rom_do};
                    r_d.st = ENG_RX_LO;
                end
            end
            ENG_RX_LO: begin
                if (phase_end) begin
                    if (r_q.bit_i == '0) begin
                        r_d.st = ENG_GAP;
                    end else begin
                        r_d.st    = ENG_RX_HI;
                        r_d.bit_i = r_q.bit_i - 1'b1;
                    end
                end
            end
            ENG_GAP: begin
                if (phase_end) begin
                    r_d.st   = ENG_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ENG_IDLE, tx: '0, bit_i: '0, rx: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    logic in_tx;
    assign in_tx   = (r_q.st == ENG_TX_LO1) || (r_q.st == ENG_TX_HI) || (r_q.st == ENG_TX_LO2);
    assign active  = (r_q.st != ENG_IDLE);
    assign rom_cs  = (r_q.st != ENG_IDLE) && (r_q.st != ENG_GAP);
    assign rom_sck = (r_q.st == ENG_TX_HI) || (r_q.st == ENG_RX_HI);
    assign rom_di  = in_tx ? r_q.tx[r_q.bit_i] : 1'b0;
    assign done    = r_q.done;
    assign data    = r_q.rx;

endmodule

// File: rtl/rom_image_check.sv
module rom_image_check #(
    parameter int ADDR_W       = 6,
    parameter int WORD_W       = 16,
    parameter int MAC_BYTE_OFS = 20,
    parameter int MAC_BYTES    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   loaded,
    output logic                   image_ok,
    output logic [MAC_BYTES*8-1:0] station_addr
);
    localparam int FIRST_WORD = MAC_BYTE_OFS / 2;
    localparam int N_WORDS    = (MAC_BYTES + 1) / 2;

    logic [N_WORDS-1:0][WORD_W-1:0] mw_d, mw_q;
    logic                           blank_d, blank_q;
    logic [MAC_BYTES*8-1:0]         mac_raw;

    always_comb begin
        mw_d    = mw_q;
        blank_d = blank_q;
        if (wr_en) begin
            if (wr_addr == '0) begin
                blank_d = (wr_data == '0) || (wr_data == '1);
            end
            for (int i = 0; i < N_WORDS; i++) begin
                if (wr_addr == ADDR_W'(FIRST_WORD + i)) mw_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mw_q    <= '0;
            blank_q <= 1'b1;
        end else begin
            mw_q    <= mw_d;
            blank_q <= blank_d;
        end
    end

    // Little-endian unpacking: even byte offset is the low byte of a word
    for (genvar k = 0; k < MAC_BYTES; k++) begin : g_octet
        assign mac_raw[8*k +: 8] = mw_q[k/2][(k%2)*8 +: 8];
    end

    assign image_ok     = loaded && !blank_q;
    assign station_addr = image_ok ? mac_raw : '0;

endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
    import cfg_rom_pkg::*;
#(
    parameter int PHASE_CLKS   = 4,
    parameter int ADDR_W       = 6,
    parameter int WORD_W       = 16,
    parameter int MAC_BYTE_OFS = 20,
    parameter int MAC_BYTES    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic [ADDR_W-1:0]      host_addr,
    output logic                   host_ack,
    output logic [WORD_W-1:0]      host_data,
    output logic                   busy,
    output logic                   load_done,
    output logic                   image_ok,
    output logic [MAC_BYTES*8-1:0] station_addr,
    output logic                   rom_cs,
    output logic                   rom_sck,
    output logic                   rom_di,
    input  logic                   rom_do
);
    localparam logic [ADDR_W-1:0] LAST_WORD = '1;

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] nxt;
        logic              done;
        logic              ack;
        logic [WORD_W-1:0] data;
    } ctl_regs_t;

    ctl_regs_t c_d, c_q;

    logic              eng_start, eng_active, eng_done, phase_end;
    logic [ADDR_W-1:0] eng_addr;
    logic [WORD_W-1:0] eng_data;
    logic              img_wr;

    always_comb begin
        c_d       = c_q;
        c_d.ack   = 1'b0;
        eng_start = 1'b0;
        eng_addr  = c_q.nxt;
        img_wr    = 1'b0;
        case (c_q.st)
            CTL_LOAD_ISSUE: begin
                eng_start = 1'b1;
                c_d.st    = CTL_LOAD_WAIT;
            end
            CTL_LOAD_WAIT: begin
                if (eng_done) begin
                    img_wr = 1'b1;
                    if (c_q.nxt == LAST_WORD) begin
                        c_d.st   = CTL_READY;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.nxt = c_q.nxt + 1'b1;
                        c_d.st  = CTL_LOAD_ISSUE;
                    end
                end
            end
            CTL_READY: begin
                if (host_req) begin
                    eng_start = 1'b1;
                    eng_addr  = host_addr;
                    c_d.st    = CTL_HOST_WAIT;
                end
            end
            CTL_HOST_WAIT: begin
                if (eng_done) begin
                    c_d.ack  = 1'b1;
                    c_d.data = eng_data;
                    c_d.st   = CTL_READY;
                end
            end
            default: c_d.st = CTL_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: CTL_LOAD_ISSUE, nxt: '0, done: 1'b0, ack: 1'b0, data: '0};
        end else begin
            c_q <= c_d;
        end
    end

    rom_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_active),
        .phase_end (phase_end)
    );

    rom_bit_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .addr      (eng_addr),
        .phase_end (phase_end),
        .rom_do    (rom_do),
        .active    (eng_active),
        .rom_cs    (rom_cs),
        .rom_sck   (rom_sck),
        .rom_di    (rom_di),
        .done      (eng_done),
        .data      (eng_data)
    );

    rom_image_check #(
        .ADDR_W       (ADDR_W),
        .WORD_W       (WORD_W),
        .MAC_BYTE_OFS (MAC_BYTE_OFS),
        .MAC_BYTES    (MAC_BYTES)
    ) u_image (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (img_wr),
        .wr_addr      (c_q.nxt),
        .wr_data      (eng_data),
        .loaded       (c_q.done),
        .image_ok     (image_ok),
        .station_addr (station_addr)
    );

    assign busy      = (c_q.st != CTL_READY);
    assign load_done = c_q.done;
    assign host_ack  = c_q.ack;
    assign host_data = c_q.data;

endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk #(
    parameter int PHASE_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic host_ack,
    input logic busy,
    input logic load_done,
    input logic image_ok,
    input logic rom_cs,
    input logic rom_sck,
    input logic rom_di
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (rom_sck) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sck |-> rom_cs); // R2

    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sck && $past(rom_sck)) |-> $stable(rom_di)); // R4

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_sck) |-> (hi_cnt == 32'(PHASE_CLKS))); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done); // R6

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> busy); // R6

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        image_ok |-> load_done); // R7

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R9

    AST_NO_ACK_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> load_done); // R10

endmodule

bind cfg_rom_loader cfg_rom_loader_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ack  (host_ack),
    .busy      (busy),
    .load_done (load_done),
    .image_ok  (image_ok),
    .rom_cs    (rom_cs),
    .rom_sck   (rom_sck),
    .rom_di    (rom_di)
);

// File: tb/cfg_rom_loader_tb.sv
module cfg_rom_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_ack, busy, load_done, image_ok;
    logic [15:0] host_data;
    logic [47:0] station_addr;
    logic        rom_cs, rom_sck, rom_di, rom_do;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_rom_loader #(.PHASE_CLKS(PHASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
        .host_ack(host_ack), .host_data(host_data), .busy(busy),
        .load_done(load_done), .image_ok(image_ok), .station_addr(station_addr),
        .rom_cs(rom_cs), .rom_sck(rom_sck), .rom_di(rom_di), .rom_do(rom_do)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [64];
    int          rise_n = 0;
    logic [8:0]  cmd_sh = '0;
    int          xfers = 0;
    int          cmd_err = 0;
    int          order_err = 0;
    int          seq_next = 0;
    bit          seq_check = 0;
    logic [5:0]  cur_addr = '0;

    always @(posedge rom_cs) rise_n = 0;

    always @(posedge rom_sck) begin
        rise_n = rise_n + 1;
        if (rise_n <= 9) cmd_sh = {cmd_sh[7:0], rom_di};
        if (rise_n == 9) begin
            xfers++;
            if (cmd_sh[8:6] != 3'b110) cmd_err++;
            cur_addr = cmd_sh[5:0];
            if (seq_check) begin
                if (int'(cmd_sh[5:0]) != seq_next) order_err++;
                seq_next++;
            end
        end
    end

    assign rom_do = (rise_n >= 10 && rise_n <= 25) ? mem[cur_addr][25 - rise_n] : 1'b0;

    // ---------------- monitors ----------------
    int viol2 = 0, viol4 = 0, hi = 0, ack_cnt = 0, cyc = 0;

    always @(negedge clk) begin
        if (rom_sck && !rom_cs) viol2++;
        if (rom_sck) hi++;
        else if (hi != 0) begin
            if (hi != PHASE) viol4++;
            hi = 0;
        end
        if (host_ack) ack_cnt++;
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=%0d expected<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- expected values ----------------
    function automatic bit exp_ok(input logic [15:0] w0);
        return !((w0 == 16'h0000) || (w0 == 16'hFFFF));
    endfunction

    function automatic logic [47:0] exp_station();
        logic [47:0] s = '0;
        if (!exp_ok(mem[0])) return '0;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] w = mem[10 + k/2];
            s[8*k +: 8] = (k % 2 == 0) ? w[7:0] : w[15:8];
        end
        return s;
    endfunction

    task automatic run_load(input int variant);
        int t;
        if (variant == 0) begin
            for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
        end
        case (variant)
            1: mem[0] = 16'hFFFF;
            2: mem[0] = 16'h0000;
            3: mem[0] = 16'h0001;
            4: mem[0] = 16'hFFFE;
            default: if (!exp_ok(mem[0])) mem[0] = 16'h1234;
        endcase
        @(negedge clk);
        rst_n = 1'b0;
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rom_cs && !rom_sck, "R1 bus idle in reset", {rom_cs, rom_sck}, 0);
        chk(!load_done && !image_ok && !host_ack, "R1 flags clear in reset",
            {load_done, image_ok, host_ack}, 0);
        xfers = 0; order_err = 0; cmd_err = 0; seq_next = 0; seq_check = 1; ack_cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy && !load_done, "R6 busy at load start", {busy, load_done}, 2);
        t = 0;
        while (!load_done && t < 40000) begin
            @(negedge clk);
            t++;
            host_req  = (t % 211 == 0);   // R10 requests while loading
            host_addr = 6'($urandom);
        end
        host_req = 1'b0;
        seq_check = 0;
        chk(xfers == 64, "R6 one transfer per word", xfers, 64);
        chk(order_err == 0, "R6 ascending word order", order_err, 0);
        chk(cmd_err == 0, "R3 read opcode 110", cmd_err, 0);
        chk(ack_cnt == 0, "R10 no ack during load", ack_cnt, 0);
        repeat (3) @(negedge clk);
        chk(xfers == 64 && !busy, "R10 no extra transfer after load", xfers, 64);
        chk(image_ok == exp_ok(mem[0]), "R7 image presence", image_ok, exp_ok(mem[0]));
        chk(station_addr == exp_station(), "R8 station address", station_addr, exp_station());
    endtask

    task automatic host_read(input logic [5:0] a);
        int x0, t, a0;
        x0 = xfers;
        a0 = ack_cnt;
        @(negedge clk);
        host_req = 1'b1; host_addr = a;
        @(negedge clk);
        host_addr = ~a;   // R10 request while busy, must be dropped
        @(negedge clk);
        host_req = 1'b0;
        t = 0;
        while (!host_ack && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(host_ack, "R9 ack seen", host_ack, 1);
        chk(host_data == mem[a], "R9 R5 host word", host_data, mem[a]);
        chk(cur_addr == a, "R3 address MSB first", cur_addr, a);
        repeat (4) @(negedge clk);
        chk(xfers == x0 + 1, "R10 busy request ignored", xfers, x0 + 1);
        chk(ack_cnt == a0 + 1, "R9 single ack", ack_cnt, a0 + 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_load(0);
        host_read(6'd0);
        host_read(6'd63);
        for (int i = 0; i < 6; i++) host_read(6'($urandom));
        run_load(1);
        run_load(2);
        run_load(3);
        host_read(6'd10);
        run_load(4);
        host_read(6'd12);
        chk(viol2 == 0, "R2 clock only under select", viol2, 0);
        chk(viol4 == 0, "R4 high phase width", viol4, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule